// File: doc/BRIEF.md
# Windowed Event Rate Counter

This block measures how often some event happens inside a repeating window of clock cycles. Every cycle the surrounding logic presents a small unsigned number saying how many occurrences it saw in that cycle. While a window is open the block adds that number into an accumulator and advances a cycle counter. When the cycle counter reaches the programmed window length, the block copies the event total and the elapsed cycle count into output registers, zeroes both counters and opens the next window without any further command.

The window length is loaded through a write strobe and a bus-wide data word. Only the low bits that fit the cycle counter are kept. A stored length of zero halts measurement. A one-cycle result strobe marks each update of the output registers, so downstream logic such as a capture buffer can record every window in sequence. Between updates the outputs keep the last completed result. A reader should therefore take the latched cycle count, not the value it wrote, as the true length behind the latched event total.

Top module: `ecnt_top`

## Requirements
- R1: After a nonzero length N is written, the N-th following clock edge latches a cycle count of N and an event total equal to the sum of the per-cycle inputs sampled at those N edges. The input present at the write edge is not counted.
- R2: While the stored length is zero, no result strobe is raised and the output registers keep their values, whatever the event input carries.
- R3: The per-cycle event input is $clog2(MAX_EVENTS+1) bits wide. Every value up to the all-ones value is added in full.
- R4: Only the low $clog2(MAX_INTERVAL+1) bits of the written word are stored. The latched cycle count equals that truncated value, not the written word.
- R5: The event accumulator is wide enough that a window of the largest length, with the all-ones input on every cycle, is totalled without wrap-around.
- R6: Windows follow each other without a gap. Each result covers only the cycles of its own window, including a length of one, where every cycle yields a result.
- R7: While a window is in progress, the output registers hold the previous result.
- R8: A write during a window discards the partial counts and restarts timing with the new length. Until the new window completes, the outputs keep the last completed result.
- R9: The result strobe is high for exactly the cycle in which the output registers show a new result, and it is low otherwise.
- R10: A synchronous active-high reset zeroes the stored length, both counters, the output registers and the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| interval_wr | input | 1 | Loads a new window length and restarts the window |
| interval_in | input | BUS_W | Window length in cycles; only the low bits that fit the cycle counter are kept |
| event_count | input | $clog2(MAX_EVENTS+1) | Number of event occurrences in this cycle |
| result_events | output | $clog2(MAX_INTERVAL+1)+$clog2(MAX_EVENTS+1) | Event total of the last completed window |
| result_cycles | output | $clog2(MAX_INTERVAL+1) | Cycle count of the last completed window |
| result_valid | output | 1 | One-cycle pulse when the result registers update |

## Verification
On every cycle the assertions check four things. A result strobe always carries a cycle count equal to the stored length. A result never holds more events than its cycle count allows. The outputs do not move unless the strobe is high. A zero length or a fresh write produces no strobe on the next cycle. Only the bench scenarios can show that the totals are the exact sums of the stimulus. They also cover truncation of the written word, the discarding of partial counts on a restart, the full-length window without wrap-around, and the reset values.

// File: rtl/ecnt_pkg.sv
package ecnt_pkg;

    // Bits needed to hold every value from zero to maxv; at least one bit.
    function automatic int unsigned span_bits(input int unsigned maxv);
        int unsigned w;
        w = $clog2(maxv + 1);
        if (w == 0) begin
            w = 1;
        end
        return w;
    endfunction

endpackage

// File: rtl/ecnt_window.sv
module ecnt_window #(
    parameter int unsigned CYC_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CYC_W-1:0] length,
    output logic [CYC_W-1:0] elapsed,
    output logic             window_end
);

    typedef struct packed {
        logic [CYC_W-1:0] cyc;
    } win_t;

    win_t             win_d;
    win_t             win_q;
    logic [CYC_W-1:0] step;

    always_comb begin
        win_d      = win_q;
        step       = win_q.cyc + 1'b1;
        window_end = run && (step == length);
        elapsed    = step;
        if (!run || window_end) begin
            win_d.cyc = '0;
        end else begin
            win_d.cyc = step;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

endmodule

// File: rtl/ecnt_accum.sv
module ecnt_accum #(
    parameter int unsigned IN_W  = 3,
    parameter int unsigned ACC_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             window_end,
    input  logic [IN_W-1:0]  events,
    output logic [ACC_W-1:0] total
);

    typedef struct packed {
        logic [ACC_W-1:0] sum;
    } acc_t;

    acc_t acc_d;
    acc_t acc_q;

    always_comb begin
        acc_d = acc_q;
        total = acc_q.sum + ACC_W'(events);
        if (!run || window_end) begin
            acc_d.sum = '0;
        end else begin
            acc_d.sum = total;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

endmodule

// File: rtl/ecnt_result.sv
module ecnt_result #(
    parameter int unsigned CYC_W = 12,
    parameter int unsigned ACC_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [ACC_W-1:0] total_in,
    input  logic [CYC_W-1:0] cycles_in,
    output logic [ACC_W-1:0] total_out,
    output logic [CYC_W-1:0] cycles_out,
    output logic             strobe
);

    typedef struct packed {
        logic [ACC_W-1:0] total;
        logic [CYC_W-1:0] cycles;
        logic             strobe;
    } res_t;

    res_t res_d;
    res_t res_q;

    always_comb begin
        res_d        = res_q;
        res_d.strobe = take;
        if (take) begin
            res_d.total  = total_in;
            res_d.cycles = cycles_in;
        end
        total_out  = res_q.total;
        cycles_out = res_q.cycles;
        strobe     = res_q.strobe;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

endmodule

// File: rtl/ecnt_top.sv
module ecnt_top #(
    parameter int unsigned MAX_INTERVAL = 4095,
    parameter int unsigned MAX_EVENTS   = 4,
    parameter int unsigned BUS_W        = 32,
    localparam int unsigned CYC_W = ecnt_pkg::span_bits(MAX_INTERVAL),
    localparam int unsigned EVT_W = ecnt_pkg::span_bits(MAX_EVENTS),
    localparam int unsigned ACC_W = CYC_W + EVT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             interval_wr,
    input  logic [BUS_W-1:0] interval_in,
    input  logic [EVT_W-1:0] event_count,
    output logic [ACC_W-1:0] result_events,
    output logic [CYC_W-1:0] result_cycles,
    output logic             result_valid
);

    typedef struct packed {
        logic [CYC_W-1:0] len;
    } cfg_t;

    cfg_t             cfg_d;
    cfg_t             cfg_q;
    logic             counting;
    logic             window_end;
    logic [CYC_W-1:0] elapsed;
    logic [ACC_W-1:0] total;
    logic [CYC_W-1:0] interval_q;

    always_comb begin
        cfg_d = cfg_q;
        if (interval_wr) begin
            cfg_d.len = interval_in[CYC_W-1:0];
        end
        counting   = (cfg_q.len != '0) && !interval_wr;
        interval_q = cfg_q.len;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    ecnt_window #(.CYC_W(CYC_W)) u_window (
        .clk        (clk),
        .rst        (rst),
        .run        (counting),
        .length     (cfg_q.len),
        .elapsed    (elapsed),
        .window_end (window_end)
    );

    ecnt_accum #(.IN_W(EVT_W), .ACC_W(ACC_W)) u_accum (
        .clk        (clk),
        .rst        (rst),
        .run        (counting),
        .window_end (window_end),
        .events     (event_count),
        .total      (total)
    );

    ecnt_result #(.CYC_W(CYC_W), .ACC_W(ACC_W)) u_result (
        .clk        (clk),
        .rst        (rst),
        .take       (window_end),
        .total_in   (total),
        .cycles_in  (elapsed),
        .total_out  (result_events),
        .cycles_out (result_cycles),
        .strobe     (result_valid)
    );

endmodule

// File: rtl/ecnt_top_chk.sv
module ecnt_top_chk #(
    parameter int unsigned MAX_INTERVAL = 4095,
    parameter int unsigned MAX_EVENTS   = 4,
    localparam int unsigned CYC_W  = ecnt_pkg::span_bits(MAX_INTERVAL),
    localparam int unsigned EVT_W  = ecnt_pkg::span_bits(MAX_EVENTS),
    localparam int unsigned ACC_W  = CYC_W + EVT_W,
    localparam int unsigned EV_TOP = (1 << EVT_W) - 1
) (
    input logic             clk,
    input logic             rst,
    input logic             interval_wr,
    input logic [CYC_W-1:0] interval_q,
    input logic [ACC_W-1:0] result_events,
    input logic [CYC_W-1:0] result_cycles,
    input logic             result_valid
);

    // R1: a fresh result always spans exactly the stored length
    p_cycles_match_r1: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (result_cycles == interval_q));

    // R2: a zero length yields no result on the following cycle
    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        ((interval_q == '0) && !interval_wr) |=> !result_valid);

    // R5: a total never exceeds what its window could hold
    p_events_bound_r5: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (longint'(result_events) <= longint'(result_cycles) * longint'(EV_TOP)));

    // R7: outputs move only together with the strobe
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!result_valid && !$past(rst)) |-> ($stable(result_events) && $stable(result_cycles)));

    // R8: a write never produces a result on the next cycle
    p_write_no_result_r8: assert property (@(posedge clk) disable iff (rst)
        interval_wr |=> !result_valid);

endmodule

bind ecnt_top ecnt_top_chk #(
    .MAX_INTERVAL (MAX_INTERVAL),
    .MAX_EVENTS   (MAX_EVENTS)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .interval_wr   (interval_wr),
    .interval_q    (interval_q),
    .result_events (result_events),
    .result_cycles (result_cycles),
    .result_valid  (result_valid)
);

// File: tb/ecnt_top_bench.sv
`timescale 1ns/1ps
module ecnt_top_bench;

    localparam int unsigned MAX_INTERVAL = 4095;
    localparam int unsigned MAX_EVENTS   = 4;
    localparam int unsigned BUS_W        = 32;
    localparam int unsigned CYC_W        = 12;
    localparam int unsigned EVT_W        = 3;
    localparam int unsigned ACC_W        = 15;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             interval_wr = 1'b0;
    logic [BUS_W-1:0] interval_in = '0;
    logic [EVT_W-1:0] event_count = '0;
    logic [ACC_W-1:0] result_events;
    logic [CYC_W-1:0] result_cycles;
    logic             result_valid;

    int checks = 0;
    int errors = 0;
    bit reported = 1'b0;

    always #4 clk = ~clk;

    ecnt_top #(
        .MAX_INTERVAL (MAX_INTERVAL),
        .MAX_EVENTS   (MAX_EVENTS),
        .BUS_W        (BUS_W)
    ) u_ecnt_top (
        .clk           (clk),
        .rst           (rst),
        .interval_wr   (interval_wr),
        .interval_in   (interval_in),
        .event_count   (event_count),
        .result_events (result_events),
        .result_cycles (result_cycles),
        .result_valid  (result_valid)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    endtask

    // one clock edge with the given event count; returns just after the edge
    task automatic cyc(input int ev);
        event_count = EVT_W'(ev);
        @(posedge clk);
        #1;
    endtask

    // load a length; the event input at this edge must be dropped
    task automatic write_len(input logic [BUS_W-1:0] v);
        interval_wr = 1'b1;
        interval_in = v;
        event_count = '1;
        @(posedge clk);
        #1;
        interval_wr = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cyc(0);
        cyc(0);
        chk("R10", "events after reset", result_events, 0);
        chk("R10", "cycles after reset", result_cycles, 0);
        chk("R10", "valid after reset", result_valid, 0);
        rst = 1'b0;
    endtask

    task automatic t_idle();
        int seen = 0;
        for (int i = 0; i < 20; i++) begin
            cyc(5);
            if (result_valid) seen++;
        end
        chk("R2", "strobes while length is zero", seen, 0);
        chk("R2", "events held at zero", result_events, 0);
    endtask

    task automatic t_basic();
        int pa[6] = '{1, 0, 3, 2, 4, 1};
        int pb[6] = '{7, 7, 0, 0, 5, 6};
        int early = 0;
        int moved = 0;
        write_len(6);
        for (int i = 0; i < 6; i++) begin
            cyc(pa[i]);
            if (i < 5 && result_valid) early++;
        end
        chk("R9", "strobe before window end", early, 0);
        chk("R9", "strobe at window end", result_valid, 1);
        chk("R1", "first window events", result_events, 11);
        chk("R1", "first window cycles", result_cycles, 6);
        for (int i = 0; i < 6; i++) begin
            cyc(pb[i]);
            if (i < 5 && (result_valid || result_events != 11 || result_cycles != 6)) moved++;
        end
        chk("R7", "outputs moved mid window", moved, 0);
        chk("R6", "second window events", result_events, 25);
        chk("R6", "second window cycles", result_cycles, 6);
        cyc(0);
        chk("R9", "strobe drops after one cycle", result_valid, 0);
    endtask

    task automatic t_restart();
        int moved = 0;
        write_len(8);
        for (int i = 0; i < 3; i++) cyc(2);
        chk("R8", "old events kept before restart", result_events, 25);
        write_len(4);
        cyc(1); cyc(2); cyc(3);
        if (result_valid || result_events != 25 || result_cycles != 6) moved++;
        chk("R8", "old result kept after restart", moved, 0);
        cyc(1);
        chk("R8", "restart strobe", result_valid, 1);
        chk("R8", "restart events exclude partial", result_events, 7);
        chk("R8", "restart cycles", result_cycles, 4);
    endtask

    task automatic t_truncate();
        write_len(32'h0001_0005);
        for (int i = 0; i < 4; i++) cyc(3);
        chk("R4", "no strobe before truncated length", result_valid, 0);
        cyc(3);
        chk("R4", "strobe at truncated length", result_valid, 1);
        chk("R4", "cycles equal truncated length", result_cycles, 5);
        chk("R4", "events over truncated window", result_events, 15);
    endtask

    task automatic t_len_one();
        int pv[3] = '{4, 0, 6};
        write_len(1);
        for (int i = 0; i < 3; i++) begin
            cyc(pv[i]);
            chk("R6", "length one strobe", result_valid, 1);
            chk("R6", "length one events", result_events, pv[i]);
            chk("R6", "length one cycles", result_cycles, 1);
        end
    endtask

    task automatic t_stop();
        int seen = 0;
        write_len(0);
        for (int i = 0; i < 10; i++) begin
            cyc(5);
            if (result_valid) seen++;
        end
        chk("R2", "strobes after zero write", seen, 0);
        chk("R2", "events held after zero write", result_events, 6);
        chk("R2", "cycles held after zero write", result_cycles, 1);
    endtask

    task automatic t_full();
        int seen = 0;
        write_len(MAX_INTERVAL);
        for (int i = 0; i < int'(MAX_INTERVAL) - 1; i++) begin
            cyc(7);
            if (result_valid) seen++;
        end
        chk("R5", "no strobe inside full window", seen, 0);
        cyc(7);
        chk("R3", "full window strobe", result_valid, 1);
        chk("R5", "full window events", result_events, 4095 * 7);
        chk("R5", "full window cycles", result_cycles, 4095);
    endtask

    task automatic t_reset_mid();
        int seen = 0;
        write_len(10);
        for (int i = 0; i < 4; i++) cyc(2);
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
        chk("R10", "events cleared by reset", result_events, 0);
        chk("R10", "cycles cleared by reset", result_cycles, 0);
        for (int i = 0; i < 12; i++) begin
            cyc(2);
            if (result_valid) seen++;
        end
        chk("R10", "length cleared by reset", seen, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        t_reset();
        t_idle();
        t_basic();
        t_restart();
        t_truncate();
        t_len_one();
        t_stop();
        t_full();
        t_reset_mid();
        report();
    end

endmodule